// File: doc/BRIEF.md
# Folded Radix-4 Booth Programmable FIR Filter

This block is a programmable finite-impulse-response filter that time-shares a small group of radix-4 Booth multiply lanes. One output needs several clock cycles, and the folding happens on two axes. The taps are split into groups of `LANES`, and each cycle serves one group. The samples are worked through one Booth digit at a time. Each stored sample is kept as a row of non-overlapping 2-bit slices. On every cycle, the 3-bit recoding window for the current digit is rebuilt from the current slice and the upper bit of the slice below it. The lowest slice uses an implicit zero below it.

Software loads the tap weights through a one-word write port. A sample is offered with a single-cycle strobe. While idle, the filter accepts the sample, shifts it into the delay line and runs `(TAPS/LANES) * (DATA_W/2)` accumulation cycles. It then presents a full-precision signed sum with a one-cycle valid pulse. The lanes produce one's-complement partial products. Their negation carries are counted and added once at the root of the adder tree, instead of one carry per lane.

The controller has three states: `ST_IDLE`, `ST_RUN` and `ST_EMIT`. Its transitions are:
- `ST_IDLE` → `ST_RUN` when a sample is accepted.
- `ST_RUN` → `ST_RUN` while digit/group steps remain.
- `ST_RUN` → `ST_EMIT` on the last step.
- `ST_EMIT` → `ST_IDLE` unconditionally.

Reset places the controller in `ST_IDLE`.

Top module: `fbf_top`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, and every coefficient and every delay-line entry is zero, so the first sample accepted after reset yields 0 until coefficients are written.
- R2: A cycle with coef_we high stores coef_data (two's complement) as the weight of tap coef_addr, where tap 0 multiplies the newest sample.
- R3: A sample on in_data is accepted on a rising edge where in_valid is high and the filter is idle. It becomes tap 0's sample, and every older sample moves one tap further.
- R4: For each accepted sample n, out_data equals the sum over k of c[k]·x[n−k] as a signed ACC_W-bit value. Samples before the first one after reset count as zero.
- R5: out_valid is high for exactly one cycle, visible after the STEPS-th rising edge following the accepting edge, with STEPS = (TAPS/LANES)·(DATA_W/2).
- R6: in_valid pulses from the accepting edge through the out_valid cycle are ignored: they alter neither the current output nor the delay line seen by later outputs.
- R7: Booth recoding is exact at the extremes of both operands (−512 and +511 for 10-bit data). Digit s uses sample bits 2s+1, 2s and 2s−1, with bit −1 taken as zero.
- R8: A coefficient write changes only the addressed tap's weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Tap index for the write |
| coef_data | input | COEF_W | Signed coefficient value |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W+COEF_W+$clog2(TAPS) | Signed filter output |

## Verification
The assertions assume that coefficients are written only while the filter is idle. A write during `ST_RUN` would mix old and new weights inside one output. They also assume that `TAPS` and `LANES` are powers of two, and that `DATA_W` is even. The bench respects these conditions: it issues coefficient writes only between outputs, after out_valid has fallen, and it keeps the default geometry. The stray strobes used for R6 are the only inputs applied during a computation.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EMIT = 2'd2
    } fbf_state_e;

endpackage

// File: rtl/fbf_booth_lane.sv
// One radix-4 Booth lane: turns a 3-bit recoding window and a coefficient
// into a one's-complement partial product placed at digit weight 4^slice.
module fbf_booth_lane #(
    parameter int COEF_W = 10,
    parameter int ACC_W  = 24,
    parameter int SL_W   = 3
) (
    input  logic [COEF_W-1:0] coef,
    input  logic [2:0]        window,
    input  logic [SL_W-1:0]   slice,
    output logic [ACC_W-1:0]  pp,
    output logic              neg
);
    logic [ACC_W-1:0] cx;
    logic [ACC_W-1:0] mag;

    always_comb begin
        cx  = {{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef};
        mag = '0;
        neg = 1'b0;
        unique case (window)
            3'b000, 3'b111: begin mag = '0;      neg = 1'b0; end
            3'b001, 3'b010: begin mag = cx;      neg = 1'b0; end
            3'b011:         begin mag = cx << 1; neg = 1'b0; end
            3'b100:         begin mag = cx << 1; neg = 1'b1; end
            3'b101, 3'b110: begin mag = cx;      neg = 1'b1; end
        endcase
        pp = (neg ? ~mag : mag) << {slice, 1'b0};
    end
endmodule

// File: rtl/fbf_adder_tree.sv
// Balanced adder tree over the lanes; negation carries are merged into a
// single count that is scaled to the digit weight and added at the root.
module fbf_adder_tree #(
    parameter int LANES = 4,
    parameter int ACC_W = 24,
    parameter int SL_W  = 3
) (
    input  logic [ACC_W-1:0] pp    [LANES],
    input  logic             neg   [LANES],
    input  logic [SL_W-1:0]  slice,
    output logic [ACC_W-1:0] sum
);
    localparam int NODES = 2 * LANES - 1;

    logic [ACC_W-1:0] node [NODES];
    logic [ACC_W-1:0] ncnt;

    for (genvar l = 0; l < LANES; l++) begin : g_leaf
        assign node[LANES-1+l] = pp[l];
    end

    for (genvar j = 0; j < LANES - 1; j++) begin : g_node
        assign node[j] = node[2*j+1] + node[2*j+2];
    end

    always_comb begin
        ncnt = '0;
        for (int l = 0; l < LANES; l++) begin
            ncnt = ncnt + ACC_W'(neg[l]);
        end
    end

    assign sum = node[0] + (ncnt << {slice, 1'b0});
endmodule

// File: rtl/fbf_sequencer.sv
module fbf_sequencer
    import fbf_pkg::*;
#(
    parameter int SLICES = 5,
    parameter int GROUPS = 4,
    parameter int SL_W   = 3,
    parameter int GR_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            start,
    output logic            run,
    output logic            emit,
    output logic            busy,
    output logic [SL_W-1:0] slice_idx,
    output logic [GR_W-1:0] grp_idx
);
    localparam int STEPS = SLICES * GROUPS;

    fbf_state_e state_q, state_d;
    logic       last;

    assign last = (slice_idx == SL_W'(SLICES - 1)) && (grp_idx == GR_W'(GROUPS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_RUN;
            ST_RUN:  if (last)     state_d = ST_EMIT;
            ST_EMIT:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start = 1'b0;
        run   = 1'b0;
        emit  = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin start = in_valid; busy = 1'b0; end
            ST_RUN:  run  = 1'b1;
            ST_EMIT: emit = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_idx <= '0;
            grp_idx   <= '0;
        end else if (start) begin
            slice_idx <= '0;
            grp_idx   <= '0;
        end else if (run) begin
            if (slice_idx == SL_W'(SLICES - 1)) begin
                slice_idx <= '0;
                grp_idx   <= grp_idx + 1'b1;
            end else begin
                slice_idx <= slice_idx + 1'b1;
            end
        end
    end

    // checker counter: cycles since the accepting edge
    logic [15:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lat_q <= '0;
        else if (start) lat_q <= '0;
        else if (run)   lat_q <= lat_q + 1'b1;
    end

    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (lat_q == 16'(STEPS)));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> !emit);
endmodule

// File: rtl/fbf_top.sv
module fbf_top
    import fbf_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int COEF_W = 10,
    parameter int TAPS   = 16,
    parameter int LANES  = 4,
    localparam int TAP_W = $clog2(TAPS),
    localparam int ACC_W = DATA_W + COEF_W + TAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_we,
    input  logic [TAP_W-1:0]  coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    localparam int SLICES = DATA_W / 2;
    localparam int GROUPS = TAPS / LANES;
    localparam int SL_W   = (SLICES > 1) ? $clog2(SLICES) : 1;
    localparam int GR_W   = TAP_W - $clog2(LANES);
    localparam int LN_W   = $clog2(LANES);

    logic [TAPS-1:0][SLICES-1:0][1:0] hist_q;
    logic [TAPS-1:0][COEF_W-1:0]      coef_q;
    logic [ACC_W-1:0]                 acc_q;

    logic            start, run, emit, busy;
    logic [SL_W-1:0] slice_idx;
    logic [GR_W-1:0] grp_idx;

    fbf_sequencer #(
        .SLICES(SLICES), .GROUPS(GROUPS), .SL_W(SL_W), .GR_W(GR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .start(start), .run(run), .emit(emit), .busy(busy),
        .slice_idx(slice_idx), .grp_idx(grp_idx)
    );

    // delay line of 2-bit sub-data slices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (start) begin
            for (int t = TAPS - 1; t > 0; t--) hist_q[t] <= hist_q[t-1];
            for (int s = 0; s < SLICES; s++) hist_q[0][s] <= in_data[2*s +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       coef_q <= '0;
        else if (coef_we) coef_q[coef_addr] <= coef_data;
    end

    logic [ACC_W-1:0] lane_pp  [LANES];
    logic             lane_neg [LANES];
    logic [ACC_W-1:0] step_sum;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TAP_W-1:0]  tap;
        logic [DATA_W:0]   ext;
        logic [2:0]        window;

        assign tap = {grp_idx, LN_W'(l)};

        always_comb begin
            ext = '0;
            for (int s = 0; s < SLICES; s++) ext[2*s+1 +: 2] = hist_q[tap][s];
            window = ext[{slice_idx, 1'b0} +: 3];
        end

        fbf_booth_lane #(.COEF_W(COEF_W), .ACC_W(ACC_W), .SL_W(SL_W)) u_lane (
            .coef(coef_q[tap]), .window(window), .slice(slice_idx),
            .pp(lane_pp[l]), .neg(lane_neg[l])
        );
    end

    fbf_adder_tree #(.LANES(LANES), .ACC_W(ACC_W), .SL_W(SL_W)) u_tree (
        .pp(lane_pp), .neg(lane_neg), .slice(slice_idx), .sum(step_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (start) acc_q <= '0;
        else if (run)   acc_q <= acc_q + step_sum;
    end

    assign out_valid = emit;
    assign out_data  = acc_q;

    a_r4_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc_q == '0));

    a_r6_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid) |=> $stable(hist_q));
endmodule

// File: tb/tb_fbf_top.sv
`timescale 1ns/1ps
module tb_fbf_top;
    localparam int DATA_W = 10;
    localparam int COEF_W = 10;
    localparam int TAPS   = 16;
    localparam int LANES  = 4;
    localparam int TAP_W  = $clog2(TAPS);
    localparam int ACC_W  = DATA_W + COEF_W + TAP_W;
    localparam int STEPS  = (TAPS / LANES) * (DATA_W / 2);
    localparam int NVEC   = 16;
    localparam int STIM [NVEC] = '{1, -1, 511, -512, 0, 37, -200, 511,
                                   511, -512, -512, 85, -341, 2, 170, -3};

    logic              clk = 1'b0;
    logic              rst_n;
    logic              coef_we;
    logic [TAP_W-1:0]  coef_addr;
    logic [COEF_W-1:0] coef_data;
    logic              in_valid;
    logic [DATA_W-1:0] in_data;
    logic              out_valid;
    logic [ACC_W-1:0]  out_data;

    fbf_top #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS), .LANES(LANES)) dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int hist_m [TAPS];
    int coef_m [TAPS];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_out();
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += longint'(coef_m[k]) * longint'(hist_m[k]);
        return s;
    endfunction

    task automatic write_coef(input int k, input int v);
        coef_we   = 1'b1;
        coef_addr = TAP_W'(k);
        coef_data = COEF_W'(v);
        @(negedge clk);
        coef_we   = 1'b0;
        coef_m[k] = v;
    endtask

    // push a sample; optionally inject a stray strobe while busy
    task automatic push(input int x, input bit stray, input int stray_x, input string req);
        int cnt;
        longint exp;
        in_valid = 1'b1;
        in_data  = DATA_W'(x);
        for (int t = TAPS - 1; t > 0; t--) hist_m[t] = hist_m[t-1];
        hist_m[0] = x;
        exp = model_out();
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 1;
        while (!out_valid && cnt < 1000) begin
            if (stray && (cnt == 3 || cnt == STEPS)) begin
                in_valid = 1'b1;
                in_data  = DATA_W'(stray_x);
            end
            @(negedge clk);
            in_valid = 1'b0;
            cnt++;
        end
        // R5: valid appears STEPS edges after the accepting edge
        check(cnt == STEPS + 1, "R5 latency", cnt, STEPS + 1);
        check(longint'($signed(out_data)) == exp, req, longint'($signed(out_data)), exp);
        if (stray) begin
            in_valid = 1'b1;
            in_data  = DATA_W'(stray_x);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R5 single pulse", out_valid, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; coef_we = 1'b0; coef_addr = '0; coef_data = '0;
        in_valid = 1'b0; in_data = '0;
        for (int k = 0; k < TAPS; k++) begin hist_m[k] = 0; coef_m[k] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid low in reset", out_valid, 0);
        check(out_data == '0, "R1 data zero in reset", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid low after reset", out_valid, 0);
        push(300, 1'b0, 0, "R1 zero weights give zero");

        // R2: program all weights, extremes at both ends (R7)
        for (int k = 0; k < TAPS; k++) write_coef(k, ((k * 73 + 11) % 1024) - 512);
        write_coef(0, -512);
        write_coef(TAPS - 1, 511);

        // R3/R4/R7: vector table walk
        for (int i = 0; i < NVEC; i++) push(STIM[i], 1'b0, 0, "R4 convolution");

        // R6: stray strobes during computation are dropped
        push(123, 1'b1, -77, "R6 stray ignored current");
        push(-5, 1'b0, 0, "R6 stray ignored later");

        // R8: rewrite one tap only
        write_coef(5, 200);
        push(64, 1'b0, 0, "R8 single tap update");

        // R2: impulse response reads back tap 0 then tap 1
        for (int k = 0; k < TAPS; k++) write_coef(k, k - 8);
        for (int i = 0; i < TAPS; i++) push(0, 1'b0, 0, "R3 flush");
        push(1, 1'b0, 0, "R2 impulse tap0");
        push(0, 1'b0, 0, "R3 impulse shifts to tap1");

        // R7: most negative operands everywhere
        for (int k = 0; k < TAPS; k++) write_coef(k, -512);
        for (int i = 0; i < TAPS; i++) push(-512, 1'b0, 0, "R7 extreme operands");
        for (int k = 0; k < TAPS; k++) write_coef(k, 511);
        push(511, 1'b0, 0, "R7 mixed extremes");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule